// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns one 32-bit virtual address at a time into a physical address. It reads descriptors from an in-memory table through a one-word read port. A level-1 entry either maps a 4 MB superpage directly or points at a level-2 table of 4 KB page entries. The walker returns the physical address, a three-bit read/write/execute mask, a page-size flag and, when the walk fails, a fault. A fault carries a numeric code and raises a one-cycle trap, which is an instruction trap for fetches and a data trap otherwise.

Two cases skip the table. When translation is off, the address passes through unchanged. When translation is on, a privileged access below 2 GB goes to IO space: it keeps its address with bit 31 forced high. Both cases get full permissions. The walker handles a single request. It raises `done` for one cycle and then keeps its result on the outputs until the next request completes.

Top module: `pt_walker`

## Requirements
- R1: Out of reset the walker is idle. `busy`, `done`, `memReq`, `instTrap` and `dataTrap` are low, and `physAddr`, `faultStat` and `faultAddr` are zero.
- R2: With `mmuOn` low, the result is `physAddr` equal to the request address, `protMask` 3'b111 and `bigPage` 0, and no memory read is issued.
- R3: With `mmuOn` high, `reqUser` low and address bit 31 clear, the result is the address with bit 31 set, `protMask` 3'b111 and `bigPage` 0, and no memory read is issued.
- R4: The level-1 read address is `{tableBase[31:12], va[31:22], 2'b00}`. `memReq` and `memAddr` stay steady until `memValid` is seen.
- R5: A descriptor's type is held in bits [1:0] and its exist flag in bit 2. A level-1 type 3 with exist set is a superpage and gives `{desc[31:22], va[21:0]}` with `bigPage` 1. With exist clear it gives fault 0x0B.
- R6: A level-1 type 0 with exist clear gives fault 0x05. With exist set, the level-2 read address is `{desc[31:12], va[21:12], 2'b00}`.
- R7: A level-2 entry with exist clear gives fault 0x08. A present type-0 entry gives `{entry[31:12], va[11:0]}` with `bigPage` 0.
- R8: `protMask` bit 0 (read) comes from descriptor bit 8, bit 1 (write) from bit 7 and bit 2 (execute) from bit 6. A privileged walked access never takes a permission fault.
- R9: `reqKind` is encoded 0 = read, 1 = write, 2 = execute. A user access whose matching permission bit is clear faults with 0x11, 0x12 or 0x13 respectively.
- R10: A level-1 type of 1 or 2, or a level-2 type other than 0, gives fault 0x1F.
- R11: On a fault, `fault` is 1, `physAddr`, `protMask` and `bigPage` are zero, `faultStat` takes the code and `faultAddr` takes the virtual address. A successful walk leaves `faultStat` and `faultAddr` unchanged.
- R12: On a fault, `instTrap` pulses together with `done` when the kind is execute, and `dataTrap` pulses otherwise. Neither pulses on success.
- R13: `done` is a one-cycle pulse, and the result outputs hold their values after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a translation (sampled while idle) |
| reqAddr | input | 32 | Virtual address |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| reqUser | input | 1 | Access made from user mode |
| tableBase | input | 32 | Level-1 table base; low 12 bits ignored |
| mmuOn | input | 1 | Translation enable |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | 32 | Descriptor word address |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| physAddr | output | 32 | Translated address |
| protMask | output | 3 | {exec, write, read} permissions |
| bigPage | output | 1 | 1 = 4 MB superpage, 0 = 4 KB |
| fault | output | 1 | Last walk faulted |
| faultStat | output | 8 | Last fault code |
| faultAddr | output | 32 | Last faulting virtual address |
| instTrap | output | 1 | Instruction trap pulse |
| dataTrap | output | 1 | Data trap pulse |

## Verification
The checker takes for granted that the memory side answers a request with a `memValid` pulse only while `memReq` is high, and that the port holds no stale response across requests. The bench memory model raises `memValid` for exactly one cycle after a fixed delay, and only for a pending request. The checker also assumes that `reqValid` matters only while the walker is idle. The bench pulses it for one cycle and waits for `done` before it issues the next request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 32;
  localparam int PAGE_SH  = 12;
  localparam int SUPER_SH = 22;
  localparam int CODE_W   = 8;
  localparam int KIND_W   = 2;
  localparam int PROT_W   = 3;
  localparam int EXIST_B  = 2;
  localparam int RD_B     = 8;
  localparam int WR_B     = 7;
  localparam int EX_B     = 6;

  localparam logic [VA_W-1:0] PAGE_HI  = {VA_W{1'b1}} << PAGE_SH;
  localparam logic [VA_W-1:0] SUPER_HI = {VA_W{1'b1}} << SUPER_SH;
  localparam logic [VA_W-1:0] IO_BIT   = {1'b1, {(VA_W-1){1'b0}}};

  localparam logic [1:0] TYP_SUPER = 2'd3;
  localparam logic [1:0] TYP_TABLE = 2'd0;
  localparam logic [KIND_W-1:0] KIND_EX = 2'd2;

  localparam logic [CODE_W-1:0] FC_NONE       = 8'h00;
  localparam logic [CODE_W-1:0] FC_SUPER_MISS = 8'h0B;
  localparam logic [CODE_W-1:0] FC_L1_MISS    = 8'h05;
  localparam logic [CODE_W-1:0] FC_L2_MISS    = 8'h08;
  localparam logic [CODE_W-1:0] FC_PERM_BASE  = 8'h11;
  localparam logic [CODE_W-1:0] FC_BAD_TYPE   = 8'h1F;

  typedef enum logic [1:0] {RT_OFF, RT_IO, RT_SUPER, RT_PAGE} route_e;

  typedef struct packed {
    logic              capReq;
    logic              capDesc;
    logic              selL2;
    logic              finish;
    route_e            route;
    logic [CODE_W-1:0] code;
  } strobe_t;

  typedef struct packed {
    logic [1:0]        rdType;
    logic              rdExist;
    logic [CODE_W-1:0] permCode;
  } dpstat_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqUser,
  input  logic    reqHigh,
  input  logic    mmuOn,
  input  logic    memValid,
  input  dpstat_t stat,
  output strobe_t stb,
  output logic    memReq,
  output logic    busy,
  output logic    done
);
  typedef enum logic [2:0] {S_IDLE, S_L1, S_L2, S_CHECK, S_DONE} state_e;

  state_e st, stNext;
  route_e rt, rtNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_IDLE;
      rt <= RT_OFF;
    end else begin
      st <= stNext;
      rt <= rtNext;
    end
  end

  always_comb begin
    stNext    = st;
    rtNext    = rt;
    stb       = '0;
    stb.route = rt;
    case (st)
      S_IDLE: begin
        if (reqValid) begin
          stb.capReq = 1'b1;
          if (!mmuOn) begin
            rtNext = RT_OFF;
            stNext = S_CHECK;
          end else if (!reqUser && !reqHigh) begin
            rtNext = RT_IO;
            stNext = S_CHECK;
          end else begin
            stNext = S_L1;
          end
        end
      end
      S_L1: begin
        if (memValid) begin
          stb.capDesc = 1'b1;
          if (stat.rdType == TYP_SUPER) begin
            if (stat.rdExist) begin
              rtNext = RT_SUPER;
              stNext = S_CHECK;
            end else begin
              stb.finish = 1'b1;
              stb.code   = FC_SUPER_MISS;
              stNext     = S_DONE;
            end
          end else if (stat.rdType == TYP_TABLE) begin
            if (stat.rdExist) begin
              rtNext = RT_PAGE;
              stNext = S_L2;
            end else begin
              stb.finish = 1'b1;
              stb.code   = FC_L1_MISS;
              stNext     = S_DONE;
            end
          end else begin
            stb.finish = 1'b1;
            stb.code   = FC_BAD_TYPE;
            stNext     = S_DONE;
          end
        end
      end
      S_L2: begin
        stb.selL2 = 1'b1;
        if (memValid) begin
          stb.capDesc = 1'b1;
          if (!stat.rdExist) begin
            stb.finish = 1'b1;
            stb.code   = FC_L2_MISS;
            stNext     = S_DONE;
          end else if (stat.rdType != TYP_TABLE) begin
            stb.finish = 1'b1;
            stb.code   = FC_BAD_TYPE;
            stNext     = S_DONE;
          end else begin
            stNext = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        stb.finish = 1'b1;
        stb.code   = (rt == RT_SUPER || rt == RT_PAGE) ? stat.permCode : FC_NONE;
        stNext     = S_DONE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  assign memReq = (st == S_L1) || (st == S_L2);
  assign busy   = (st != S_IDLE);
  assign done   = (st == S_DONE);
endmodule

// File: rtl/ptw_dp.sv
module ptw_dp
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [KIND_W-1:0] reqKind,
  input  logic              reqUser,
  input  logic [VA_W-1:0]   tableBase,
  input  logic [VA_W-1:0]   memData,
  output dpstat_t           stat,
  output logic [VA_W-1:0]   memAddr,
  output logic [VA_W-1:0]   physAddr,
  output logic [PROT_W-1:0] protMask,
  output logic              bigPage,
  output logic              fault,
  output logic [CODE_W-1:0] faultStat,
  output logic [VA_W-1:0]   faultAddr,
  output logic              instTrap,
  output logic              dataTrap
);
  logic [VA_W-1:0]   va;
  logic [VA_W-1:0]   desc;
  logic [KIND_W-1:0] kind;
  logic              user;

  logic [VA_W-1:0]   l1Addr, l2Addr;
  logic [PROT_W-1:0] descProt;
  logic              permMiss;

  // Each table index is a word index, so the 4 KB-aligned base is ORed with index*4.
  assign l1Addr = (tableBase & PAGE_HI) | ((va >> (SUPER_SH - 2)) & ~(PAGE_HI | 32'h3));
  assign l2Addr = (desc & PAGE_HI) | ((va >> (PAGE_SH - 2)) & ~(PAGE_HI | 32'h3));
  assign memAddr = stb.selL2 ? l2Addr : l1Addr;

  assign descProt = {desc[EX_B], desc[WR_B], desc[RD_B]};
  always_comb begin
    case (kind)
      2'd0:    permMiss = !descProt[0];
      2'd1:    permMiss = !descProt[1];
      2'd2:    permMiss = !descProt[2];
      default: permMiss = 1'b0;
    endcase
  end

  assign stat.rdType   = memData[1:0];
  assign stat.rdExist  = memData[EXIST_B];
  assign stat.permCode = (user && permMiss) ? (FC_PERM_BASE + CODE_W'(kind)) : FC_NONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      va        <= '0;
      kind      <= '0;
      user      <= 1'b0;
      desc      <= '0;
      physAddr  <= '0;
      protMask  <= '0;
      bigPage   <= 1'b0;
      fault     <= 1'b0;
      faultStat <= '0;
      faultAddr <= '0;
      instTrap  <= 1'b0;
      dataTrap  <= 1'b0;
    end else begin
      instTrap <= 1'b0;
      dataTrap <= 1'b0;
      if (stb.capReq) begin
        va   <= reqAddr;
        kind <= reqKind;
        user <= reqUser;
      end
      if (stb.capDesc) desc <= memData;
      if (stb.finish) begin
        if (stb.code != FC_NONE) begin
          fault     <= 1'b1;
          physAddr  <= '0;
          protMask  <= '0;
          bigPage   <= 1'b0;
          faultStat <= stb.code;
          faultAddr <= va;
          instTrap  <= (kind == KIND_EX);
          dataTrap  <= (kind != KIND_EX);
        end else begin
          fault <= 1'b0;
          case (stb.route)
            RT_OFF: begin
              physAddr <= va;
              protMask <= '1;
              bigPage  <= 1'b0;
            end
            RT_IO: begin
              physAddr <= va | IO_BIT;
              protMask <= '1;
              bigPage  <= 1'b0;
            end
            RT_SUPER: begin
              physAddr <= (desc & SUPER_HI) | (va & ~SUPER_HI);
              protMask <= descProt;
              bigPage  <= 1'b1;
            end
            default: begin
              physAddr <= (desc & PAGE_HI) | (va & ~PAGE_HI);
              protMask <= descProt;
              bigPage  <= 1'b0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [KIND_W-1:0] reqKind,
  input  logic              reqUser,
  input  logic [VA_W-1:0]   tableBase,
  input  logic              mmuOn,
  output logic              memReq,
  output logic [VA_W-1:0]   memAddr,
  input  logic              memValid,
  input  logic [VA_W-1:0]   memData,
  output logic              busy,
  output logic              done,
  output logic [VA_W-1:0]   physAddr,
  output logic [PROT_W-1:0] protMask,
  output logic              bigPage,
  output logic              fault,
  output logic [CODE_W-1:0] faultStat,
  output logic [VA_W-1:0]   faultAddr,
  output logic              instTrap,
  output logic              dataTrap
);
  strobe_t stb;
  dpstat_t stat;

  ptw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqUser(reqUser),
    .reqHigh(reqAddr[VA_W-1]), .mmuOn(mmuOn), .memValid(memValid),
    .stat(stat), .stb(stb), .memReq(memReq), .busy(busy), .done(done)
  );

  ptw_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqKind(reqKind),
    .reqUser(reqUser), .tableBase(tableBase), .memData(memData), .stat(stat),
    .memAddr(memAddr), .physAddr(physAddr), .protMask(protMask),
    .bigPage(bigPage), .fault(fault), .faultStat(faultStat),
    .faultAddr(faultAddr), .instTrap(instTrap), .dataTrap(dataTrap)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memValid,
  input logic [VA_W-1:0]   memAddr,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [VA_W-1:0]   physAddr,
  input logic [PROT_W-1:0] protMask,
  input logic              bigPage,
  input logic [CODE_W-1:0] faultStat,
  input logic              instTrap,
  input logic              dataTrap
);
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !done);

  p_trap_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({instTrap, dataTrap}));

  p_trap_with_fault_r12: assert property (@(posedge clk) disable iff (!rstN)
    (instTrap || dataTrap) |-> done && fault);

  p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> physAddr == '0 && protMask == '0 && !bigPage && faultStat != '0);

  p_stat_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    done && !fault |-> $stable(faultStat));
endmodule

bind pt_walker pt_walker_chk chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memValid(memValid),
  .memAddr(memAddr), .busy(busy), .done(done), .fault(fault),
  .physAddr(physAddr), .protMask(protMask), .bigPage(bigPage),
  .faultStat(faultStat), .instTrap(instTrap), .dataTrap(dataTrap)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic [31:0] tableBase = 32'h0010_0ABC;
  logic        mmuOn = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        busy, done, bigPage, fault, instTrap, dataTrap;
  logic [31:0] physAddr, faultAddr;
  logic [2:0]  protMask;
  logic [7:0]  faultStat;

  int total = 0;
  int bad = 0;
  int reads = 0;
  int cnt = 0;
  logic [31:0] firstRd = '0;

  always #2.5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqUser(reqUser), .tableBase(tableBase), .mmuOn(mmuOn),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .busy(busy), .done(done), .physAddr(physAddr), .protMask(protMask),
    .bigPage(bigPage), .fault(fault), .faultStat(faultStat),
    .faultAddr(faultAddr), .instTrap(instTrap), .dataTrap(dataTrap)
  );

  function automatic logic [31:0] memFn(input logic [31:0] a);
    case (a)
      32'h0010_0804: memFn = 32'h0C00_01C7; // superpage rwx
      32'h0010_0808: memFn = 32'h0C40_0003; // superpage, exist clear
      32'h0010_080C: memFn = 32'h0030_0000; // table, exist clear
      32'h0010_0810: memFn = 32'h0000_0005; // type 1
      32'h0010_0814: memFn = 32'h0D00_0007; // superpage, no perms
      32'h0010_0000: memFn = 32'h0020_0004; // table at 0x200000
      32'h0020_0014: memFn = 32'h0345_6104; // page, read only
      32'h0020_0004: memFn = 32'h0000_0000; // page missing
      32'h0020_0008: memFn = 32'h0777_70C4; // page, write+exec
      32'h0020_000C: memFn = 32'h0000_0006; // level-2 type 2
      default:       memFn = 32'h0000_0000;
    endcase
  endfunction

  always @(negedge clk) begin
    if (memValid) begin
      memValid <= 1'b0;
      cnt      <= 0;
    end else if (memReq) begin
      if (cnt == LAT - 1) begin
        memValid <= 1'b1;
        memData  <= memFn(memAddr);
        reads    <= reads + 1;
        if (reads == 0) firstRd <= memAddr;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        user;
    logic        mmu;
    logic [31:0] phys;
    logic [2:0]  prot;
    logic        big;
    logic [7:0]  code;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 2'd0, 1'b1, 1'b0, 32'h1234_5678, 3'd7, 1'b0, 8'h00, 8'd2},  // R2
    '{32'h0000_2000, 2'd0, 1'b0, 1'b1, 32'h8000_2000, 3'd7, 1'b0, 8'h00, 8'd3},  // R3
    '{32'h8040_0123, 2'd2, 1'b1, 1'b1, 32'h0C00_0123, 3'd7, 1'b1, 8'h00, 8'd5},  // R5
    '{32'h0000_5678, 2'd0, 1'b1, 1'b1, 32'h0345_6678, 3'd1, 1'b0, 8'h00, 8'd7},  // R7
    '{32'h0000_5678, 2'd1, 1'b1, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h12, 8'd9},  // R9
    '{32'h0000_5678, 2'd2, 1'b1, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h13, 8'd9},  // R9
    '{32'h0000_2000, 2'd0, 1'b1, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h11, 8'd9},  // R9
    '{32'h0000_2000, 2'd1, 1'b1, 1'b1, 32'h0777_7000, 3'd6, 1'b0, 8'h00, 8'd8},  // R8
    '{32'h0000_1234, 2'd0, 1'b1, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h08, 8'd7},  // R7
    '{32'h0000_3000, 2'd0, 1'b1, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h1F, 8'd10}, // R10
    '{32'h8080_0000, 2'd0, 1'b0, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h0B, 8'd5},  // R5
    '{32'h80C0_0000, 2'd1, 1'b0, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h05, 8'd6},  // R6
    '{32'h8100_0000, 2'd0, 1'b0, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h1F, 8'd10}, // R10
    '{32'h8140_0000, 2'd1, 1'b0, 1'b1, 32'h0D00_0000, 3'd0, 1'b1, 8'h00, 8'd8},  // R8
    '{32'h8140_0000, 2'd2, 1'b1, 1'b1, 32'h0000_0000, 3'd0, 1'b0, 8'h13, 8'd9},  // R9
    '{32'h8000_0010, 2'd1, 1'b0, 1'b0, 32'h8000_0010, 3'd7, 1'b0, 8'h00, 8'd2}   // R2
  };

  task automatic runOne(input vec_t v, output bit ok);
    int waitCnt;
    @(negedge clk);
    reqAddr  = v.va;
    reqKind  = v.kind;
    reqUser  = v.user;
    mmuOn    = v.mmu;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitCnt  = 0;
    while (!done && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    ok = done;
    if (!ok) chk(1'b0, "watchdog", 64'(waitCnt), 64'd200);
  endtask

  logic [7:0]  expStat = '0;
  logic [31:0] expFA = '0;

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    int rd0;
    string tg;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !memReq && !instTrap && !dataTrap, "R1 ctl",
        {busy, done, memReq, instTrap, dataTrap}, 64'd0);
    chk(physAddr == 0 && faultStat == 0 && faultAddr == 0, "R1 regs",
        {faultStat, physAddr}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      tg = $sformatf("R%0d vec%0d", v.tag, i);
      rd0 = reads;
      runOne(v, ok);
      if (ok) begin
        chk(physAddr == v.phys && protMask == v.prot && bigPage == v.big && fault == (v.code != 0),
            tg, {fault, bigPage, protMask, physAddr}, {(v.code != 0), v.big, v.prot, v.phys});
        if (v.code != 0) begin
          expStat = v.code;
          expFA   = v.va;
        end
        // R11: fault registers latch only on a fault
        chk(faultStat == expStat && faultAddr == expFA, {tg, " R11"},
            {faultStat, faultAddr}, {expStat, expFA});
        // R12: trap kind follows access kind
        chk(instTrap == (v.code != 0 && v.kind == 2) && dataTrap == (v.code != 0 && v.kind != 2),
            {tg, " R12"}, {instTrap, dataTrap}, {(v.code != 0 && v.kind == 2), (v.code != 0 && v.kind != 2)});
        if (!v.mmu || (!v.user && !v.va[31]))
          chk(reads == rd0, {tg, " R2/R3 no read"}, 64'(reads - rd0), 64'd0);
        if (i == 2)
          chk(firstRd == 32'h0010_0804, "R4 l1 addr", firstRd, 64'h0010_0804);
        if (i == 3) begin
          @(negedge clk);
          chk(!done, "R13 pulse", done, 64'd0);
          @(negedge clk);
          chk(physAddr == v.phys && protMask == v.prot, "R13 hold", physAddr, v.phys);
        end
      end
    end

    // R6: second-level read address seen for a table walk
    tableBase = 32'h0010_0000;
    begin
      vec_t v;
      int r0;
      v = VECS[3];
      r0 = reads;
      runOne(v, ok);
      chk(reads == r0 + 2 && physAddr == 32'h0345_6678, "R6 two reads",
          64'(reads - r0), 64'd2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule